// File: doc/BRIEF.md
# Encoder Period Difference Monitor

This block watches a single raw encoder pulse line. It counts how many system-clock cycles pass between one rising edge of the pulse and the next. It then reports the change from the previous such period as an 8-bit signed number. When the change does not fit in 8 bits, that number is clamped to the nearest limit and never wraps. The line is asynchronous to the system clock, so it first passes through a flop synchronizer and a rising-edge detector.

Each completed period is also compared with a legal window, which comes from the slowest and fastest allowed encoder frequency. The default parameters assume a 50 MHz system clock and an encoder rate of 200 Hz to 3500 Hz. A small sequencer controls what the block reports after reset:

- **WAIT_EDGE** is the state after reset. The first synchronized rising edge moves it to FIRST (transition *arm*) and only starts a measurement.
- **FIRST**: the next edge completes the first period. Transition *seed* publishes that period without a difference and moves to TRACK.
- **TRACK**: every further edge completes a period. Transition *step* stays in TRACK and publishes the period together with its clamped difference.

Reset from any state returns the sequencer to WAIT_EDGE.

Top module: `enc_period_monitor`

## Requirements
- R1: While reset is high, and after it, period_o, in_range_o, diff_o and diff_vld_o are all 0 until a period completes, and the sequencer is back in WAIT_EDGE.
- R2: The reported period equals the number of clock cycles between two consecutive synchronized rising edges of enc_in. The input must hold each level for at least 2 clock cycles.
- R3: A rising transition applied to enc_in reaches the outputs on the third rising clock edge after it is applied: two synchronizer flops, then the output register. This is the cycle after the period completes.
- R4: The period counter stops at its all-ones value, 2^CNT_W-1, instead of wrapping. A longer period is reported as that value.
- R5: in_range_o is 1 exactly when PER_MIN <= period <= PER_MAX, where PER_MIN = floor(CLK_HZ/FMAX_HZ) and PER_MAX = floor(CLK_HZ/FMIN_HZ). It is updated with every reported period.
- R6: The first completed period after reset updates period_o and in_range_o but raises no difference strobe.
- R7: diff_vld_o is a single-cycle pulse. It occurs once for each completed period from the second one on, and at no other time.
- R8: diff_o is the new period minus the previous period, as 8-bit two's complement, when the result lies in -128..127.
- R9: A difference above 127 gives 127 and a difference below -128 gives -128. The decision is made on the full-width difference.
- R10: The first rising edge after reset changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in | input | 1 | Raw encoder pulse, asynchronous |
| period_o | output | CNT_W | Latest measured period in clock cycles (18 bits by default) |
| in_range_o | output | 1 | Latest period lies in the legal window |
| diff_o | output | DIFF_W | Clamped signed difference from the previous period (8 bits by default) |
| diff_vld_o | output | 1 | One-cycle strobe marking a new diff_o |

## Verification
The assertions take for granted that enc_in holds each level for at least two clocks, so that every pulse yields exactly one synchronized edge. They also assume enc_in is low when reset is released, so the edge detector does not see a false edge. The stimulus holds every pulse high for two cycles and keeps every period at four cycles or more. It changes enc_in only away from the active clock edge and lets pending edges drain before each reset. The bench uses a scaled clock frequency so that the legal window and the counter's stop value both fall within a short run. Its directed periods land on the window edges and on the exact clamp thresholds, in both directions.

// File: rtl/enc_mon_pkg.sv
package enc_mon_pkg;

    // Sequencer states of the period monitor
    typedef enum logic [1:0] {
        MON_WAIT_EDGE = 2'd0,  // no edge seen since reset
        MON_FIRST     = 2'd1,  // measuring the first period
        MON_TRACK     = 2'd2   // every period yields a difference
    } mon_state_e;

    // Default width of the reported difference
    localparam int MON_DIFF_W_DEF = 8;

    // Minimum synchronizer depth that is accepted
    localparam int MON_SYNC_MIN = 2;

endpackage

// File: rtl/enc_sync_edge.sv
module enc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Flop chain that resolves metastability on the raw input
    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= raw_i;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    // Copy of the synchronized level, one cycle older
    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/enc_period_ctr.sv
module enc_period_ctr #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CAP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             at_cap;

    assign at_cap = (count_q == CAP);

    // Restart loads 1 so that, at the next edge, the count equals the
    // number of cycles that have elapsed since the previous edge.
    always_ff @(posedge clk) begin
        if (rst)            count_q <= '0;
        else if (restart_i) count_q <= ONE;
        else if (!at_cap)   count_q <= count_q + ONE;
    end

    assign count_o = count_q;

endmodule

// File: rtl/enc_window_cmp.sv
module enc_window_cmp #(
    parameter int CNT_W = 18,
    parameter int LO    = 14285,
    parameter int HI    = 250000
) (
    input  logic [CNT_W-1:0] value_i,
    output logic             inside_o
);

    localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI);

    logic above_lo;
    logic below_hi;

    assign above_lo = (value_i >= LO_V);
    assign below_hi = (value_i <= HI_V);
    assign inside_o = above_lo & below_hi;

endmodule

// File: rtl/enc_diff_sat.sv
module enc_diff_sat #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]         cur_i,
    input  logic [IN_W-1:0]         prev_i,
    output logic signed [OUT_W-1:0] diff_o
);

    localparam int FW   = IN_W + 1;
    localparam int HI_I = (2 ** (OUT_W - 1)) - 1;
    localparam int LO_I = -(2 ** (OUT_W - 1));

    // Full-width signed difference, which can never overflow
    logic signed [FW-1:0] full;

    assign full = $signed({1'b0, cur_i}) - $signed({1'b0, prev_i});

    generate
        if (FW > OUT_W) begin : g_clamp
            localparam logic signed [FW-1:0] HI_V = FW'(HI_I);
            localparam logic signed [FW-1:0] LO_V = FW'(LO_I);
            logic over;
            logic under;

            assign over  = (full > HI_V);
            assign under = (full < LO_V);

            always_comb begin
                if (over)       diff_o = OUT_W'(HI_I);
                else if (under) diff_o = OUT_W'(LO_I);
                else            diff_o = full[OUT_W-1:0];
            end
        end else begin : g_wide
            // The output is wide enough for any difference: sign-extend only
            assign diff_o = OUT_W'(full);
        end
    endgenerate

endmodule

// File: rtl/enc_period_monitor.sv
module enc_period_monitor
    import enc_mon_pkg::*;
#(
    parameter  int CLK_HZ      = 50_000_000,
    parameter  int FMIN_HZ     = 200,
    parameter  int FMAX_HZ     = 3500,
    parameter  int DIFF_W      = MON_DIFF_W_DEF,
    parameter  int SYNC_STAGES = MON_SYNC_MIN,
    localparam int PER_MIN     = CLK_HZ / FMAX_HZ,
    localparam int PER_MAX     = CLK_HZ / FMIN_HZ,
    localparam int CNT_W       = $clog2(PER_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enc_in,
    output logic [CNT_W-1:0]         period_o,
    output logic                     in_range_o,
    output logic signed [DIFF_W-1:0] diff_o,
    output logic                     diff_vld_o
);

    mon_state_e state_q;
    mon_state_e state_d;

    logic                     edge_rise;
    logic [CNT_W-1:0]         live_count;
    logic                     live_inside;
    logic signed [DIFF_W-1:0] live_diff;

    logic [CNT_W-1:0]         period_q;
    logic                     in_range_q;
    logic signed [DIFF_W-1:0] diff_q;
    logic                     diff_vld_q;

    // Synchronizer and rising-edge detector
    enc_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (enc_in),
        .rise_o (edge_rise)
    );

    // Counter that stops at its maximum and restarts on every edge
    enc_period_ctr #(
        .CNT_W     (CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .restart_i (edge_rise),
        .count_o   (live_count)
    );

    // Check of the legal period window
    enc_window_cmp #(
        .CNT_W    (CNT_W),
        .LO       (PER_MIN),
        .HI       (PER_MAX)
    ) u_win (
        .value_i  (live_count),
        .inside_o (live_inside)
    );

    // Clamped difference between the ending period and the stored one
    enc_diff_sat #(
        .IN_W   (CNT_W),
        .OUT_W  (DIFF_W)
    ) u_diff (
        .cur_i  (live_count),
        .prev_i (period_q),
        .diff_o (live_diff)
    );

    // Next-state logic: arm, seed and step transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_WAIT_EDGE: if (edge_rise) state_d = MON_FIRST;
            MON_FIRST:     if (edge_rise) state_d = MON_TRACK;
            MON_TRACK:     state_d = MON_TRACK;
            default:       state_d = MON_WAIT_EDGE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= MON_WAIT_EDGE;
        else     state_q <= state_d;
    end

    // Output register, updated in the cycle after a period completes
    always_ff @(posedge clk) begin
        if (rst) begin
            period_q   <= '0;
            in_range_q <= 1'b0;
            diff_q     <= '0;
            diff_vld_q <= 1'b0;
        end else begin
            diff_vld_q <= 1'b0;
            if (edge_rise) begin
                unique case (state_q)
                    MON_WAIT_EDGE: begin
                        // arm: the count so far has no meaning
                    end
                    MON_FIRST: begin
                        period_q   <= live_count;
                        in_range_q <= live_inside;
                    end
                    MON_TRACK: begin
                        period_q   <= live_count;
                        in_range_q <= live_inside;
                        diff_q     <= live_diff;
                        diff_vld_q <= 1'b1;
                    end
                    default: begin
                        diff_vld_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign period_o   = period_q;
    assign in_range_o = in_range_q;
    assign diff_o     = diff_q;
    assign diff_vld_o = diff_vld_q;

endmodule

// File: rtl/enc_period_monitor_chk.sv
module enc_period_monitor_chk #(
    parameter int CNT_W   = 18,
    parameter int DIFF_W  = 8,
    parameter int PER_MIN = 14285,
    parameter int PER_MAX = 250000
) (
    input logic                     clk,
    input logic                     rst,
    input logic [CNT_W-1:0]         period_o,
    input logic                     in_range_o,
    input logic signed [DIFF_W-1:0] diff_o,
    input logic                     diff_vld_o
);

    localparam int FW = CNT_W + 1;
    localparam logic signed [FW-1:0] HI_V = FW'((2 ** (DIFF_W - 1)) - 1);
    localparam logic signed [FW-1:0] LO_V = FW'(-(2 ** (DIFF_W - 1)));
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(PER_MIN);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(PER_MAX);

    logic [CNT_W-1:0]     seen_prev_q;
    logic signed [FW-1:0] seen_full;

    // period_o holds the previous period until the strobe cycle
    always_ff @(posedge clk) begin
        if (rst) seen_prev_q <= '0;
        else     seen_prev_q <= period_o;
    end

    assign seen_full = $signed({1'b0, period_o}) - $signed({1'b0, seen_prev_q});

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!diff_vld_o && !in_range_o && period_o == '0 && diff_o == '0));

    assert_window_flag_R5: assert property (@(posedge clk) disable iff (rst)
        diff_vld_o |-> (in_range_o == (period_o >= MIN_V && period_o <= MAX_V)));

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        diff_vld_o |=> !diff_vld_o);

    assert_exact_diff_R8: assert property (@(posedge clk) disable iff (rst)
        (diff_vld_o && seen_full <= HI_V && seen_full >= LO_V)
            |-> (diff_o == seen_full[DIFF_W-1:0]));

    assert_clamp_high_R9: assert property (@(posedge clk) disable iff (rst)
        (diff_vld_o && seen_full > HI_V) |-> (diff_o == HI_V[DIFF_W-1:0]));

    assert_clamp_low_R9: assert property (@(posedge clk) disable iff (rst)
        (diff_vld_o && seen_full < LO_V) |-> (diff_o == LO_V[DIFF_W-1:0]));

endmodule

bind enc_period_monitor enc_period_monitor_chk #(
    .CNT_W      (CNT_W),
    .DIFF_W     (DIFF_W),
    .PER_MIN    (PER_MIN),
    .PER_MAX    (PER_MAX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .period_o   (period_o),
    .in_range_o (in_range_o),
    .diff_o     (diff_o),
    .diff_vld_o (diff_vld_o)
);

// File: tb/enc_period_monitor_tb.sv
module enc_period_monitor_tb;

    // Scaled clock rate so the window and the counter stop fit a short run
    localparam int T_CLK_HZ = 100_000;
    localparam int T_FMIN   = 200;
    localparam int T_FMAX   = 3500;
    localparam int EXP_MIN  = 28;    // floor(100000/3500)
    localparam int EXP_MAX  = 500;   // 100000/200
    localparam int EXP_CAP  = 511;   // 9-bit counter stops here

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enc = 1'b0;
    logic [8:0]        period;
    logic              in_range;
    logic signed [7:0] diff;
    logic              vld;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    int  rise_cyc [0:1023];
    int  nrise = 0;
    int  ni = 0;

    enc_period_monitor #(
        .CLK_HZ     (T_CLK_HZ),
        .FMIN_HZ    (T_FMIN),
        .FMAX_HZ    (T_FMAX)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .enc_in     (enc),
        .period_o   (period),
        .in_range_o (in_range),
        .diff_o     (diff),
        .diff_vld_o (vld)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampp(input int d);
        return (d > EXP_CAP) ? EXP_CAP : d;
    endfunction

    function automatic int sat8(input int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int win(input int p);
        return (p >= EXP_MIN && p <= EXP_MAX) ? 1 : 0;
    endfunction

    // Rising edge now, high for 2 cycles, next edge d cycles later
    task automatic send(input int d);
        enc = 1'b1;
        rise_cyc[nrise] = cyc;
        nrise++;
        repeat (2) @(negedge clk);
        enc = 1'b0;
        repeat (d - 2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 period in reset", int'(period), 0);
        check("R1 in-range in reset", int'(in_range), 0);
        check("R1 diff in reset", int'(diff), 0);
        check("R1 strobe in reset", int'(vld), 0);
        nrise = 0;
        ni = 0;
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Output monitor: every completed period is checked 3 edges after its edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ni < nrise && cyc == rise_cyc[ni] + 3) begin
                if (ni == 0) begin
                    check("R10 period after first edge", int'(period), 0);
                    check("R10 strobe after first edge", int'(vld), 0);
                end else begin
                    int raw;
                    int p;
                    raw = rise_cyc[ni] - rise_cyc[ni-1];
                    p = clampp(raw);
                    check(raw > EXP_CAP ? "R4 capped period" : "R2 period",
                          int'(period), p);
                    check("R5 in-range flag", int'(in_range), win(p));
                    if (ni == 1) begin
                        check("R6 no strobe on first period", int'(vld), 0);
                    end else begin
                        int pp;
                        int full;
                        pp = clampp(rise_cyc[ni-1] - rise_cyc[ni-2]);
                        full = p - pp;
                        check("R3 strobe timing", int'(vld), 1);
                        check((full > 127 || full < -128) ? "R9 clamped difference"
                                                          : "R8 difference",
                              int'(diff), sat8(full));
                    end
                end
                ni++;
            end else if (vld) begin
                check("R7 strobe outside completion cycle", int'(vld), 0);
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        do_reset();

        // Directed: clamp thresholds, window edges, counter stop
        send(100);
        send(227);   // +127 exact
        send(355);   // +128 -> 127
        send(227);   // -128 exact
        send(98);    // -129 -> -128
        send(28);    // lower window edge
        send(27);    // below window
        send(500);   // upper window edge
        send(501);   // above window
        send(600);   // counter stops at 511
        send(40);    // large negative clamp
        send(40);    // zero difference
        send(20);
        send(4);     // shortest legal period
        send(10);
        repeat (10) @(negedge clk);

        // Reset with state loaded
        do_reset();

        // Random periods: small steps mixed with wide jumps
        begin
            int prevd;
            prevd = 200;
            for (int i = 0; i < 60; i++) begin
                int d;
                if (($urandom % 4) == 0) begin
                    d = 4 + int'($urandom % 600);
                end else begin
                    d = prevd + int'($urandom % 61) - 30;
                    if (d < 4)   d = 4;
                    if (d > 560) d = 560;
                end
                send(d);
                prevd = d;
            end
        end
        send(10);
        repeat (10) @(negedge clk);

        // A lone edge after reset leaves the outputs untouched
        do_reset();
        send(30);
        repeat (10) @(negedge clk);
        check("R10 period after lone edge", int'(period), 0);
        check("R1 in-range after lone edge", int'(in_range), 0);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

endmodule